// File: doc/BRIEF.md
# Oversampled Serial Receiver with Two-Entry Status FIFO

This block receives asynchronous serial frames on a single line that idles high. An external pulse at sixteen times the bit rate paces the sampling. The line first passes through a synchronizer. A start is recognised on a low sample and then confirmed at the middle of the start bit. Each data bit and the stop bit are decided by a majority vote over three samples at the centre of the bit. Bits arrive least significant first. A mode input selects 8-bit or 9-bit frames.

Each finished frame goes into a small receive queue together with its ninth bit and a framing-error flag. The head entry is always present on the outputs. A read strobe removes it and exposes the next entry's data and status together, so software reads the status before it consumes the data.

A data-available flag, gated by an interrupt enable, signals waiting entries. If a frame ends while the queue is full, a sticky overrun flag is raised. From then on nothing more is accepted. The only way to clear the overrun is to drop the receive enable and raise it again.

Top module: `serial_rx_engine`

## Requirements
- R1: After reset, data_avail, irq and overrun are 0 and rd_data, rd_bit9 and rd_ferr are 0.
- R2: In 8-bit mode (frame_nine = 0), a frame made of a low start bit, eight data bits sent least significant bit first and a stop bit is delivered on rd_data, with rd_bit9 = 0.
- R3: In 9-bit mode (frame_nine = 1), the ninth bit follows the eight data bits. It is reported on rd_bit9, and the first eight bits appear on rd_data.
- R4: A frame whose stop bit is sampled low is still queued, with rd_ferr = 1. A frame with a high stop bit has rd_ferr = 0.
- R5: A low pulse that has ended before the middle of the start bit is treated as a false start: no entry is queued, and the next real frame is received correctly.
- R6: The queue holds two entries. rd_data, rd_bit9 and rd_ferr always show the oldest entry, and a pulse on rd_pop advances all three together to the next entry.
- R7: data_avail is 1 exactly while at least one entry is queued, and it is cleared only by reads. irq equals data_avail AND irq_en.
- R8: When a frame completes while two entries are waiting, overrun goes to 1, that frame is discarded, and the two waiting entries are kept.
- R9: While overrun is 1, no frame is queued, even after the queue has been emptied.
- R10: overrun returns to 0 only while rx_en is 0. After rx_en is raised again, frames are received normally.
- R11: While rx_en is 0, activity on the line queues nothing.
- R12: A single-sample glitch at the centre of a bit does not change the received value of that bit, because of the three-sample majority vote.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| tick_16x | input | 1 | One-clock pulse at sixteen times the bit rate |
| rx_en | input | 1 | Receive enable; a low level also clears overrun |
| frame_nine | input | 1 | 1 selects 9-bit frames, 0 selects 8-bit frames |
| rd_pop | input | 1 | Removes the head entry (ignored when the queue is empty) |
| irq_en | input | 1 | Interrupt enable |
| rd_data | output | 8 | Data byte of the head entry |
| rd_bit9 | output | 1 | Ninth bit of the head entry |
| rd_ferr | output | 1 | Framing-error flag of the head entry |
| data_avail | output | 1 | High while the queue is not empty |
| irq | output | 1 | data_avail gated by irq_en |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with its defaults: 16 samples per bit, a two-stage synchronizer and a two-entry queue. With a queue only two deep, three back-to-back frames without reads are enough to reach the full-queue overrun path and the drop-while-overrun path. The bench also drives the tick every fourth clock, so each frame lasts about 700 cycles and the enable-toggle recovery fits easily in the run. Driving the tick every fourth clock also means a four-clock glitch covers exactly one oversample, which tests the majority vote directly.

// File: rtl/serial_rx_pkg.sv
// Shared types and helpers for the serial receiver.
// Assumes one queue entry holds 8 data bits, the ninth bit and a framing flag.
package serial_rx_pkg;

    typedef struct packed {
        logic       ferr;
        logic       bit9;
        logic [7:0] data;
    } rx_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_t;

    // Two-of-three majority of the centre samples.
    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/serial_rx_sync.sv
// Multi-stage synchronizer for the asynchronous line.
// Assumes the line idles high; every stage resets to 1 so that reset never
// looks like a start bit.
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/serial_rx_framer.sv
// Frame assembler: detects and confirms the start bit, votes each bit at
// its centre, shifts in LSB first and emits a one-cycle frame pulse at the
// centre of the stop bit.
// Assumes OSR is a power of two and at least 4, and that frame_nine is
// stable while a frame is in flight.
module serial_rx_framer
    import serial_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_en,
    input  logic      tick,
    input  logic      line_s,
    input  logic      frame_nine,
    output logic      frm_valid,
    output rx_entry_t frm_entry
);
    localparam int CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] SMP_PRE  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] SMP_MID  = CNT_W'(OSR / 2);
    localparam logic [CNT_W-1:0] SMP_POST = CNT_W'(OSR / 2 + 1);
    localparam logic [CNT_W-1:0] SMP_LAST = CNT_W'(OSR - 1);

    rx_state_t        state;
    logic [CNT_W-1:0] smp_cnt;
    logic [3:0]       bit_idx;
    logic [8:0]       shreg;
    logic             s_pre;
    logic             s_mid;
    logic             voted;
    logic             last_bit;

    assign voted    = vote3(s_pre, s_mid, line_s);
    assign last_bit = frame_nine ? (bit_idx == 4'd8) : (bit_idx == 4'd7);

    // Capture the two early centre samples for the vote.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_pre <= 1'b1;
            s_mid <= 1'b1;
        end else if (tick) begin
            if (smp_cnt == SMP_PRE) s_pre <= line_s;
            if (smp_cnt == SMP_MID) s_mid <= line_s;
        end
    end

    // Frame state machine with its sample counter and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            smp_cnt   <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            frm_valid <= 1'b0;
            frm_entry <= '0;
        end else begin
            frm_valid <= 1'b0;
            if (!rx_en) begin
                state   <= ST_IDLE;
                smp_cnt <= '0;
                bit_idx <= '0;
            end else if (tick) begin
                smp_cnt <= smp_cnt + 1'b1;
                case (state)
                    ST_IDLE: begin
                        if (!line_s) begin
                            state   <= ST_START;
                            smp_cnt <= CNT_W'(1);
                        end else begin
                            smp_cnt <= '0;
                        end
                    end
                    ST_START: begin
                        if (smp_cnt == SMP_MID && line_s) begin
                            state   <= ST_IDLE;
                            smp_cnt <= '0;
                        end else if (smp_cnt == SMP_LAST) begin
                            state   <= ST_DATA;
                            bit_idx <= '0;
                        end
                    end
                    ST_DATA: begin
                        if (smp_cnt == SMP_POST) shreg <= {voted, shreg[8:1]};
                        if (smp_cnt == SMP_LAST) begin
                            if (last_bit) state <= ST_STOP;
                            else          bit_idx <= bit_idx + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (smp_cnt == SMP_POST) begin
                            frm_valid      <= 1'b1;
                            frm_entry.ferr <= ~voted;
                            frm_entry.data <= frame_nine ? shreg[7:0] : shreg[8:1];
                            frm_entry.bit9 <= frame_nine ? shreg[8] : 1'b0;
                            state          <= ST_IDLE;
                            smp_cnt        <= '0;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/serial_rx_fifo.sv
// Small circular receive queue. The head entry is read straight from the
// storage flops. A pop on an empty queue is ignored. A push when the queue is
// full is taken only if a pop happens in the same cycle.
// Assumes DEPTH is a power of two.
module serial_rx_fifo
    import serial_rx_pkg::*;
#(
    parameter int DEPTH = 2,
    parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  rx_entry_t        push_entry,
    input  logic             pop,
    output rx_entry_t        head,
    output logic [CNT_W-1:0] fill
);
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_TOP  = PTR_W'(DEPTH - 1);

    rx_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_pop;
    logic             do_push;

    assign do_pop  = pop && (fill != '0);
    assign do_push = push && ((fill != FULL_LVL) || do_pop);
    assign head    = mem[rd_ptr];

    // One storage slot per entry, written when the write pointer selects it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                                    mem[g] <= '0;
            else if (do_push && wr_ptr == PTR_W'(g))       mem[g] <= push_entry;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_TOP) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_TOP) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/serial_rx_engine.sv
// Top of the serial receiver: synchronizer, framer and queue, plus the
// acceptance logic that sets the sticky overrun flag. While overrun is set,
// every frame is dropped. Overrun clears while rx_en is low.
// Assumes tick_16x is a single-cycle pulse at OSR times the bit rate.
module serial_rx_engine
    import serial_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2,
    parameter int DEPTH       = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_line,
    input  logic       tick_16x,
    input  logic       rx_en,
    input  logic       frame_nine,
    input  logic       rd_pop,
    input  logic       irq_en,
    output logic [7:0] rd_data,
    output logic       rd_bit9,
    output logic       rd_ferr,
    output logic       data_avail,
    output logic       irq,
    output logic       overrun
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

    logic             line_s;
    logic             frm_valid;
    rx_entry_t        frm_entry;
    rx_entry_t        head;
    logic [CNT_W-1:0] fifo_fill;
    logic             room;
    logic             fifo_push;

    serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (rx_line),
        .sync_out (line_s)
    );

    serial_rx_framer #(.OSR(OSR)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .tick       (tick_16x),
        .line_s     (line_s),
        .frame_nine (frame_nine),
        .frm_valid  (frm_valid),
        .frm_entry  (frm_entry)
    );

    assign room      = (fifo_fill != FULL_LVL) || (rd_pop && fifo_fill != '0);
    assign fifo_push = frm_valid && rx_en && !overrun && room;

    serial_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (fifo_push),
        .push_entry (frm_entry),
        .pop        (rd_pop),
        .head       (head),
        .fill       (fifo_fill)
    );

    // Sticky overrun: set by a frame that finds no room, cleared while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                                overrun <= 1'b0;
        else if (!rx_en)                           overrun <= 1'b0;
        else if (frm_valid && !overrun && !room)   overrun <= 1'b1;
    end

    assign rd_data    = head.data;
    assign rd_bit9    = head.bit9;
    assign rd_ferr    = head.ferr;
    assign data_avail = (fifo_fill != '0);
    assign irq        = data_avail & irq_en;
endmodule

// File: rtl/serial_rx_checker.sv
// Property checker for serial_rx_engine, attached by bind.
module serial_rx_checker #(
    parameter int DEPTH = 2,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_en,
    input logic             rd_pop,
    input logic             data_avail,
    input logic             overrun,
    input logic             push,
    input logic [CNT_W-1:0] fill
);
    assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));

    assert_avail_falls_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_avail) |-> $past(rd_pop));

    assert_overrun_needs_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(fill) == CNT_W'(DEPTH));

    assert_no_push_in_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !push);

    assert_overrun_clear_by_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(overrun) |-> !$past(rx_en));

    assert_disabled_no_push_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rx_en) |-> !push);
endmodule

bind serial_rx_engine serial_rx_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .rd_pop     (rd_pop),
    .data_avail (data_avail),
    .overrun    (overrun),
    .push       (fifo_push),
    .fill       (fifo_fill)
);

// File: tb/serial_rx_engine_test.sv
// Scoreboard bench: the frame driver queues expected entries, and a monitor
// pops the design's queue and compares each entry with the expectation.
module serial_rx_engine_test;
    localparam int BIT_CLK = 64;   // 16 ticks, one every 4 clocks

    typedef struct {
        logic [7:0] d;
        logic       b9;
        logic       fe;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_line = 1'b1;
    logic tick_16x = 1'b0;
    logic rx_en = 1'b0;
    logic frame_nine = 1'b0;
    logic rd_pop = 1'b0;
    logic irq_en = 1'b0;
    logic [7:0] rd_data;
    logic rd_bit9, rd_ferr, data_avail, irq, overrun;

    int   n_tests = 0;
    int   n_fail = 0;
    int   drain_req = 0;
    bit   auto_drain = 1'b0;
    int   tick_div = 0;
    exp_t expq[$];

    serial_rx_engine uut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick_16x(tick_16x),
        .rx_en(rx_en), .frame_nine(frame_nine), .rd_pop(rd_pop), .irq_en(irq_en),
        .rd_data(rd_data), .rd_bit9(rd_bit9), .rd_ferr(rd_ferr),
        .data_avail(data_avail), .irq(irq), .overrun(overrun)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        tick_div = (tick_div + 1) % 4;
        tick_16x <= (tick_div == 0);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [8:0] val, input bit stop_v,
                              input bit glitch, input bit expect_out,
                              input string tag);
        exp_t e;
        if (expect_out) begin
            e.d = val[7:0]; e.b9 = frame_nine ? val[8] : 1'b0;
            e.fe = !stop_v; e.tag = tag;
            expq.push_back(e);
        end
        rx_line = 1'b0;
        wait_clks(BIT_CLK);
        for (int i = 0; i < (frame_nine ? 9 : 8); i++) begin
            rx_line = val[i];
            if (glitch && i == 0) begin
                wait_clks(BIT_CLK / 2);
                rx_line = ~val[i];
                wait_clks(4);
                rx_line = val[i];
                wait_clks(BIT_CLK / 2 - 4);
            end else begin
                wait_clks(BIT_CLK);
            end
        end
        rx_line = stop_v;
        wait_clks(BIT_CLK);
        rx_line = 1'b1;
        wait_clks(BIT_CLK);
    endtask

    // Monitor: pops entries when draining is allowed and compares them.
    initial begin
        forever begin
            @(negedge clk);
            if (data_avail && (auto_drain || drain_req > 0)) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R11", "unexpected entry", rd_data, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(rd_data == e.d, e.tag, "data", rd_data, e.d);
                    check(rd_bit9 == e.b9, e.tag, "ninth bit", rd_bit9, e.b9);
                    check(rd_ferr == e.fe, e.tag, "framing flag", rd_ferr, e.fe);
                    check(irq == irq_en, "R7", "irq gating", irq, irq_en);
                end
                rd_pop = 1'b1;
                @(negedge clk);
                rd_pop = 1'b0;
                if (drain_req > 0) drain_req--;
            end
        end
    end

    task automatic summary_and_end();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(negedge clk);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        summary_and_end();
    end

    initial begin
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(2);
        // R1: reset state
        check(data_avail == 1'b0, "R1", "data_avail", data_avail, 0);
        check(irq == 1'b0, "R1", "irq", irq, 0);
        check(overrun == 1'b0, "R1", "overrun", overrun, 0);
        check({rd_bit9, rd_ferr, rd_data} == 10'h0, "R1", "head", rd_data, 0);

        rx_en = 1'b1; irq_en = 1'b1; auto_drain = 1'b1;
        wait_clks(BIT_CLK);
        // R2: eight-bit frames
        send_frame(9'h0A5, 1'b1, 1'b0, 1'b1, "R2");
        send_frame(9'h03C, 1'b1, 1'b0, 1'b1, "R2");
        send_frame(9'h000, 1'b1, 1'b0, 1'b1, "R2");
        send_frame(9'h0FF, 1'b1, 1'b0, 1'b1, "R2");
        // R3: nine-bit frames
        frame_nine = 1'b1;
        send_frame(9'h15A, 1'b1, 1'b0, 1'b1, "R3");
        send_frame(9'h0C3, 1'b1, 1'b0, 1'b1, "R3");
        frame_nine = 1'b0;
        // R4: low stop bit
        send_frame(9'h081, 1'b0, 1'b0, 1'b1, "R4");
        wait_clks(BIT_CLK);
        // R12: one-sample glitch at bit centre
        send_frame(9'h00F, 1'b1, 1'b1, 1'b1, "R12");
        // R5: short low pulse, then a real frame
        rx_line = 1'b0; wait_clks(16); rx_line = 1'b1;
        wait_clks(BIT_CLK * 3);
        check(data_avail == 1'b0, "R5", "false start queued", data_avail, 0);
        send_frame(9'h096, 1'b1, 1'b0, 1'b1, "R5");
        wait_clks(BIT_CLK);

        // R6/R7/R8: fill the queue without reading, then overflow
        auto_drain = 1'b0; irq_en = 1'b0;
        send_frame(9'h011, 1'b1, 1'b0, 1'b1, "R6");
        send_frame(9'h022, 1'b0, 1'b0, 1'b1, "R6");
        wait_clks(BIT_CLK);
        check(data_avail == 1'b1, "R7", "data_avail with entries", data_avail, 1);
        check(irq == 1'b0, "R7", "irq masked", irq, 0);
        check(rd_data == 8'h11, "R6", "head before pop", rd_data, 8'h11);
        send_frame(9'h033, 1'b1, 1'b0, 1'b0, "R8");
        check(overrun == 1'b1, "R8", "overrun set", overrun, 1);
        send_frame(9'h044, 1'b1, 1'b0, 1'b0, "R9");
        check(overrun == 1'b1, "R9", "overrun sticky", overrun, 1);
        drain_req = 2;
        wait (drain_req == 0);
        wait_clks(2);
        check(data_avail == 1'b0, "R7", "data_avail after reads", data_avail, 0);
        // R9: empty queue but overrun still blocks
        send_frame(9'h055, 1'b1, 1'b0, 1'b0, "R9");
        wait_clks(BIT_CLK);
        check(data_avail == 1'b0, "R9", "frame dropped in overrun", data_avail, 0);
        check(overrun == 1'b1, "R9", "overrun held", overrun, 1);
        // R10: toggle enable to clear
        rx_en = 1'b0;
        wait_clks(4);
        check(overrun == 1'b0, "R10", "overrun cleared", overrun, 0);
        rx_en = 1'b1; auto_drain = 1'b1; irq_en = 1'b1;
        wait_clks(BIT_CLK);
        send_frame(9'h066, 1'b1, 1'b0, 1'b1, "R10");
        wait_clks(BIT_CLK);
        // R11: disabled receiver ignores the line
        rx_en = 1'b0;
        send_frame(9'h077, 1'b1, 1'b0, 1'b0, "R11");
        wait_clks(BIT_CLK);
        check(data_avail == 1'b0, "R11", "disabled reception", data_avail, 0);
        rx_en = 1'b1;
        wait_clks(BIT_CLK);
        check(expq.size() == 0, "R2", "outstanding expectations", expq.size(), 0);
        summary_and_end();
    end
endmodule